// File: doc/BRIEF.md
# Video Output Side-Channel Encoder

This block produces the timing of a digital RGB video stream, one pixel per clock: a 24-bit colour bus, data enable, pixel skip, frame sync and line sync. A pixel source is asked for data one cycle ahead through `pix_req`, and the block passes the colour and the skip flag it receives to the output bus in the next cycle. The sizes of the visible area and of the horizontal and vertical blanking are inputs. They are sampled when a frame begins, so a new geometry takes effect at a frame boundary and never partway through a frame.

The colour bus also carries control words at two fixed points. During the frame sync cycle it carries a feature word that describes the frame: rescan, interlaced, odd field and last field. On the cycle after data enable falls on the last visible line of a field, it carries a command word that asks the downstream scaler to switch to a requested slot. At every other point outside the visible area the bus is zero, and a zero bus means "select slot 0". In interlaced mode each field holds half of the configured visible lines, and the field parity alternates from one frame to the next. A separate flag reports a visible width that is too large for a rotated display.

Top module: `vid_sidechan_enc`

## Requirements
- R1: `vid_vs` is high for exactly one cycle at the start of each frame, and `vid_hs` is high in that same cycle. A frame is (field lines + `cfg_v_blank`) lines long.
- R2: `vid_hs` is high for exactly one cycle at the start of every line. Lines are `cfg_h_active + cfg_h_blank` cycles long, and `cfg_h_blank` must be at least 2.
- R3: Line 0 of a frame carries only the frame sync. Lines 1 to (field lines) are visible, and on each of them `vid_de` is high for `cfg_h_active` consecutive cycles, starting in the cycle after `vid_hs`. On all other cycles `vid_de` is low.
- R4: `pix_req` is high exactly one cycle before each cycle in which `vid_de` is high. In that `vid_de` cycle, `vid_rgb` equals the `pix_rgb` value sampled while `pix_req` was high, and `vid_skip` equals the `pix_skip` value sampled at the same time. `vid_skip` is never high while `vid_de` is low.
- R5: During the `vid_vs` cycle, `vid_rgb` is the feature word. Bit 0 is the rescan setting, bit 1 is interlaced, bit 2 is odd field, bit 3 is last field (interlaced and odd), and bits 23:4 are zero.
- R6: On the visible line that is last in its field, the cycle after `vid_de` falls carries a command word. The function code sits in bits 2:0 and is 0, meaning set slot. Bits 12:3 are zero, and bits 23:13 hold the parameter, which is the `slot_req` value sampled one cycle earlier, zero-extended.
- R7: `vid_rgb` is zero on every cycle that is not a visible pixel, a frame sync or the command cycle of R6. This includes the cycle after `vid_de` falls on any other visible line.
- R8: When interlaced is set, a field has `cfg_v_active / 2` visible lines, rounded down. The odd-field bit inverts at each frame boundary while interlaced stays set, and it is 0 in progressive frames.
- R9: The geometry, interlace and rescan inputs are taken at the frame boundary. A change made during a frame affects only the frames that follow it.
- R10: `cfg_err` is high one cycle after `cfg_rotate` is high and `cfg_h_active` is greater than 720, and is low one cycle after any other combination.
- R11: While `rst_n` is low, every output is zero. After reset is released, the first frame sync appears on the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_h_active | input | 12 | Visible pixels per line |
| cfg_h_blank | input | 12 | Blank cycles per line (at least 2) |
| cfg_v_active | input | 12 | Visible lines per frame (split over two fields when interlaced) |
| cfg_v_blank | input | 12 | Blank lines per field (at least 1) |
| cfg_interlace | input | 1 | Interlaced output |
| cfg_rescan | input | 1 | Ask the sink to show the previous frame again |
| cfg_rotate | input | 1 | Rotation enabled downstream; used only for the width check |
| slot_req | input | 3 | Requested scaler slot |
| pix_rgb | input | 24 | Pixel colour from the source |
| pix_skip | input | 1 | Pixel to be ignored by the sink |
| pix_req | output | 1 | Source must present a pixel in this cycle |
| vid_rgb | output | 24 | Colour bus, also carrying control words |
| vid_de | output | 1 | Data enable |
| vid_skip | output | 1 | Pixel skip |
| vid_vs | output | 1 | Frame sync pulse |
| vid_hs | output | 1 | Line sync pulse |
| cfg_err | output | 1 | Width too large for rotation |

## Verification
The bench aims at the smallest geometry: one pixel per line, two blank cycles, and a single visible line that is both first and last. There, an encoder that puts the slot command on the wrong line, or one cycle late, overwrites the line sync or drops the command. Interlaced runs with an odd line count check that a field holds half the lines, rounded down, and that the parity bit alternates. A design that counted the full height, or never toggled the bit, would show the wrong frame length or the wrong feature word. Geometry changes made in the middle of a frame check that the old frame keeps its length, and widths of 720 and 721, with and without rotation, probe the exact threshold of the error flag.

// File: rtl/vse_pkg.sv
package vse_pkg;

    localparam int unsigned VSE_CW    = 12;
    localparam int unsigned VSE_RGB_W = 24;
    localparam int unsigned VSE_PAR_W = 11;
    localparam int unsigned VSE_FN_W  = 3;

    typedef logic [VSE_CW-1:0]    cnt_t;
    typedef logic [VSE_CW:0]      pos_t;
    typedef logic [VSE_RGB_W-1:0] rgb_t;

    typedef struct packed {
        cnt_t h_act;
        cnt_t h_blank;
        cnt_t v_act;
        cnt_t v_blank;
        logic interlace;
        logic rescan;
    } geo_cfg_t;

    typedef struct packed {
        logic vs;
        logic hs;
        logic de;
        logic skip;
        rgb_t rgb;
    } vid_bus_t;

    typedef enum logic [1:0] {
        ZN_IDLE,
        ZN_PIX,
        ZN_FEAT,
        ZN_CMD
    } zone_e;

    localparam logic [VSE_FN_W-1:0] FN_SET_SLOT = 3'd0;

    function automatic rgb_t feature_word(logic rescan, logic inter, logic odd);
        return {20'd0, inter & odd, odd, inter, rescan};
    endfunction

    function automatic rgb_t endline_word(logic [VSE_FN_W-1:0] fn, logic [VSE_PAR_W-1:0] param);
        return {param, 10'd0, fn};
    endfunction

endpackage

// File: rtl/vse_timing.sv
module vse_timing
    import vse_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  geo_cfg_t cfg_i,
    output geo_cfg_t cfg_o,
    output logic     field_o,
    output logic     frame_start_o,
    output logic     line_start_o,
    output logic     pix_o,
    output logic     eol_o,
    output logic     last_line_o
);

    typedef struct packed {
        logic     run;
        pos_t     h;
        pos_t     v;
        logic     field;
        geo_cfg_t cfg;
    } tim_st_t;

    tim_st_t st_d, st_q;

    pos_t line_len;
    pos_t fld_lines;
    pos_t frame_lines;
    pos_t eol_pos;
    logic act_line;

    always_comb begin
        line_len    = {1'b0, st_q.cfg.h_act} + {1'b0, st_q.cfg.h_blank};
        fld_lines   = st_q.cfg.interlace ? {2'b0, st_q.cfg.v_act[VSE_CW-1:1]}
                                         : {1'b0, st_q.cfg.v_act};
        frame_lines = fld_lines + {1'b0, st_q.cfg.v_blank};
        eol_pos     = {1'b0, st_q.cfg.h_act} + pos_t'(1);

        st_d = st_q;
        if (!st_q.run) begin
            st_d.run   = 1'b1;
            st_d.cfg   = cfg_i;
            st_d.h     = '0;
            st_d.v     = '0;
            st_d.field = 1'b0;
        end else if (st_q.h == line_len - pos_t'(1)) begin
            st_d.h = '0;
            if (st_q.v == frame_lines - pos_t'(1)) begin
                st_d.v     = '0;
                st_d.cfg   = cfg_i;
                st_d.field = cfg_i.interlace & ~st_q.field;
            end else begin
                st_d.v = st_q.v + pos_t'(1);
            end
        end else begin
            st_d.h = st_q.h + pos_t'(1);
        end

        act_line      = st_q.run && (st_q.v != '0) && (st_q.v <= fld_lines);
        frame_start_o = st_q.run && (st_q.h == '0) && (st_q.v == '0);
        line_start_o  = st_q.run && (st_q.h == '0);
        pix_o         = act_line && (st_q.h != '0) && (st_q.h <= {1'b0, st_q.cfg.h_act});
        eol_o         = act_line && (st_q.h == eol_pos);
        last_line_o   = (st_q.v == fld_lines);
        cfg_o         = st_q.cfg;
        field_o       = st_q.field;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/vse_fmt.sv
module vse_fmt
    import vse_pkg::*;
#(
    parameter int unsigned SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              line_start_i,
    input  logic              pix_i,
    input  logic              eol_i,
    input  logic              last_line_i,
    input  logic              rescan_i,
    input  logic              interlace_i,
    input  logic              field_i,
    input  rgb_t              pix_rgb_i,
    input  logic              pix_skip_i,
    input  logic [SLOT_W-1:0] slot_i,
    output vid_bus_t          vid_o
);

    vid_bus_t vid_d, vid_q;
    zone_e    zone;

    always_comb begin
        if (frame_start_i) begin
            zone = ZN_FEAT;
        end else if (pix_i) begin
            zone = ZN_PIX;
        end else if (eol_i && last_line_i) begin
            zone = ZN_CMD;
        end else begin
            zone = ZN_IDLE;
        end

        vid_d      = '0;
        vid_d.vs   = frame_start_i;
        vid_d.hs   = line_start_i;
        vid_d.de   = pix_i;
        vid_d.skip = pix_i & pix_skip_i;

        unique case (zone)
            ZN_FEAT: vid_d.rgb = feature_word(rescan_i, interlace_i, field_i);
            ZN_PIX:  vid_d.rgb = pix_rgb_i;
            ZN_CMD:  vid_d.rgb = endline_word(FN_SET_SLOT, VSE_PAR_W'(slot_i));
            default: vid_d.rgb = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_q <= '0;
        end else begin
            vid_q <= vid_d;
        end
    end

    assign vid_o = vid_q;

endmodule

// File: rtl/vse_cfgchk.sv
module vse_cfgchk
    import vse_pkg::*;
#(
    parameter int unsigned MAX_ROT_WIDTH = 720
) (
    input  logic clk,
    input  logic rst_n,
    input  cnt_t h_act_i,
    input  logic rotate_i,
    output logic err_o
);

    localparam cnt_t LIMIT = cnt_t'(MAX_ROT_WIDTH);

    logic err_d, err_q;

    always_comb begin
        err_d = rotate_i && (h_act_i > LIMIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/vid_sidechan_enc.sv
module vid_sidechan_enc
    import vse_pkg::*;
#(
    parameter int unsigned SLOT_W        = 3,
    parameter int unsigned MAX_ROT_WIDTH = 720
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [VSE_CW-1:0]    cfg_h_active,
    input  logic [VSE_CW-1:0]    cfg_h_blank,
    input  logic [VSE_CW-1:0]    cfg_v_active,
    input  logic [VSE_CW-1:0]    cfg_v_blank,
    input  logic                 cfg_interlace,
    input  logic                 cfg_rescan,
    input  logic                 cfg_rotate,
    input  logic [SLOT_W-1:0]    slot_req,
    input  logic [VSE_RGB_W-1:0] pix_rgb,
    input  logic                 pix_skip,
    output logic                 pix_req,
    output logic [VSE_RGB_W-1:0] vid_rgb,
    output logic                 vid_de,
    output logic                 vid_skip,
    output logic                 vid_vs,
    output logic                 vid_hs,
    output logic                 cfg_err
);

    geo_cfg_t cfg_live;
    geo_cfg_t cfg_cur;
    logic     field;
    logic     frame_start;
    logic     line_start;
    logic     pix;
    logic     eol;
    logic     last_line;
    vid_bus_t vid;

    always_comb begin
        cfg_live.h_act     = cfg_h_active;
        cfg_live.h_blank   = cfg_h_blank;
        cfg_live.v_act     = cfg_v_active;
        cfg_live.v_blank   = cfg_v_blank;
        cfg_live.interlace = cfg_interlace;
        cfg_live.rescan    = cfg_rescan;
    end

    vse_timing u_timing (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_i         (cfg_live),
        .cfg_o         (cfg_cur),
        .field_o       (field),
        .frame_start_o (frame_start),
        .line_start_o  (line_start),
        .pix_o         (pix),
        .eol_o         (eol),
        .last_line_o   (last_line)
    );

    vse_fmt #(.SLOT_W(SLOT_W)) u_fmt (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start),
        .line_start_i  (line_start),
        .pix_i         (pix),
        .eol_i         (eol),
        .last_line_i   (last_line),
        .rescan_i      (cfg_cur.rescan),
        .interlace_i   (cfg_cur.interlace),
        .field_i       (field),
        .pix_rgb_i     (pix_rgb),
        .pix_skip_i    (pix_skip),
        .slot_i        (slot_req),
        .vid_o         (vid)
    );

    vse_cfgchk #(.MAX_ROT_WIDTH(MAX_ROT_WIDTH)) u_cfgchk (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_act_i  (cfg_h_active),
        .rotate_i (cfg_rotate),
        .err_o    (cfg_err)
    );

    assign pix_req  = pix;
    assign vid_rgb  = vid.rgb;
    assign vid_de   = vid.de;
    assign vid_skip = vid.skip;
    assign vid_vs   = vid.vs;
    assign vid_hs   = vid.hs;

endmodule

// File: rtl/vse_chk.sv
module vse_chk #(
    parameter int unsigned MAX_ROT_WIDTH = 720
) (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] cfg_h_active,
    input logic        cfg_rotate,
    input logic        pix_req,
    input logic [23:0] vid_rgb,
    input logic        vid_de,
    input logic        vid_skip,
    input logic        vid_vs,
    input logic        vid_hs,
    input logic        cfg_err
);

    logic wide_rot;
    assign wide_rot = cfg_rotate && (32'(cfg_h_active) > MAX_ROT_WIDTH);

    a_r1_vs_single: assert property (@(posedge clk) disable iff (!rst_n)
        vid_vs |=> !vid_vs);

    a_r1_vs_with_hs: assert property (@(posedge clk) disable iff (!rst_n)
        vid_vs |-> vid_hs);

    a_r2_hs_single: assert property (@(posedge clk) disable iff (!rst_n)
        vid_hs |=> !vid_hs);

    a_r3_de_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vid_de) |-> $past(vid_hs));

    a_r3_no_de_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
        vid_hs |-> !vid_de);

    a_r4_skip_in_de: assert property (@(posedge clk) disable iff (!rst_n)
        vid_skip |-> vid_de);

    a_r4_req_leads_de: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |=> vid_de);

    a_r5_feature_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        vid_vs |-> (vid_rgb[23:4] == 20'd0));

    a_r6_cmd_format: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vid_de) |-> ((vid_rgb[12:0] == 13'd0) && (vid_rgb[23:16] == 8'd0)));

    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!vid_de && !vid_vs && !$fell(vid_de)) |-> (vid_rgb == 24'd0));

    a_r8_last_needs_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_vs && vid_rgb[3]) |-> (vid_rgb[2] && vid_rgb[1]));

    a_r10_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        wide_rot |=> cfg_err);

    a_r10_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_rot |=> !cfg_err);

endmodule

bind vid_sidechan_enc vse_chk #(.MAX_ROT_WIDTH(MAX_ROT_WIDTH)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_h_active (cfg_h_active),
    .cfg_rotate   (cfg_rotate),
    .pix_req      (pix_req),
    .vid_rgb      (vid_rgb),
    .vid_de       (vid_de),
    .vid_skip     (vid_skip),
    .vid_vs       (vid_vs),
    .vid_hs       (vid_hs),
    .cfg_err      (cfg_err)
);

// File: tb/test_vid_sidechan_enc.sv
`timescale 1ns/1ps
module test_vid_sidechan_enc;

    localparam int NPH   = 16;
    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] c_hact, c_hbl, c_vact, c_vbl;
    logic        c_int, c_resc, c_rot;
    logic [2:0]  slot;
    logic [23:0] pix;
    logic        pskip;
    logic        pix_req, vid_de, vid_skip, vid_vs, vid_hs, cfg_err;
    logic [23:0] vid_rgb;

    always #2.5 clk = ~clk;

    vid_sidechan_enc i_vid_sidechan_enc (
        .clk(clk), .rst_n(rst_n),
        .cfg_h_active(c_hact), .cfg_h_blank(c_hbl),
        .cfg_v_active(c_vact), .cfg_v_blank(c_vbl),
        .cfg_interlace(c_int), .cfg_rescan(c_resc), .cfg_rotate(c_rot),
        .slot_req(slot), .pix_rgb(pix), .pix_skip(pskip),
        .pix_req(pix_req), .vid_rgb(vid_rgb), .vid_de(vid_de),
        .vid_skip(vid_skip), .vid_vs(vid_vs), .vid_hs(vid_hs),
        .cfg_err(cfg_err)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int m_hact, m_hbl, m_vact, m_vbl, m_int, m_resc, m_field;
    int bh, bv;
    int prev_pix, prev_skip, prev_slot, prev_req, prev_err;
    int since_vs, exp_len;
    bit have_len, saw_vs;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int fld(int va, int it);
        return (it != 0) ? va / 2 : va;
    endfunction

    function automatic int feat(int rs, int it, int odd);
        return (((it & odd) << 3) | (odd << 2) | (it << 1) | rs);
    endfunction

    task automatic set_cfg(int ha, int hb, int va, int vb, int it, int rs, int ro);
        c_hact = 12'(ha); c_hbl = 12'(hb); c_vact = 12'(va); c_vbl = 12'(vb);
        c_int = it[0]; c_resc = rs[0]; c_rot = ro[0];
    endtask

    task automatic drive_src();
        pix   = 24'($urandom);
        pskip = ($urandom_range(0, 3) == 0);
        slot  = 3'($urandom_range(0, 7));
        prev_pix  = int'(pix);
        prev_skip = int'(pskip);
        prev_slot = int'(slot);
    endtask

    task automatic load_model();
        m_hact = int'(c_hact); m_hbl = int'(c_hbl); m_vact = int'(c_vact);
        m_vbl = int'(c_vbl); m_resc = int'(c_resc);
        m_field = c_int ? (m_field ^ 1) : 0;
        m_int = int'(c_int);
    endtask

    task automatic step();
        int fl, e_rgb;
        bit act, e_vs, e_hs, e_de, e_cmd;
        string tag;
        fl    = fld(m_vact, m_int);
        act   = (bv >= 1) && (bv <= fl);
        e_vs  = (bh == 0) && (bv == 0);
        e_hs  = (bh == 0);
        e_de  = act && (bh >= 1) && (bh <= m_hact);
        e_cmd = act && (bh == m_hact + 1) && (bv == fl);
        if (e_vs) begin
            e_rgb = feat(m_resc, m_int, m_field);
            tag = (m_int != 0) ? "R8 feature word field bits" : "R5 feature word";
        end else if (e_de) begin
            e_rgb = prev_pix;  tag = "R4 pixel data";
        end else if (e_cmd) begin
            e_rgb = prev_slot << 13; tag = "R6 slot command";
        end else begin
            e_rgb = 0; tag = "R7 idle bus zero";
        end
        chk(vid_vs == e_vs, "R1 frame sync", int'(vid_vs), int'(e_vs));
        chk(vid_hs == e_hs, "R2 line sync", int'(vid_hs), int'(e_hs));
        chk(vid_de == e_de, "R3 data enable", int'(vid_de), int'(e_de));
        chk(vid_skip == (e_de && prev_skip != 0), "R4 skip", int'(vid_skip), int'(e_de && prev_skip != 0));
        chk(int'(vid_de) == prev_req, "R4 pix_req leads DE", prev_req, int'(vid_de));
        chk(int'(vid_rgb) == e_rgb, tag, int'(vid_rgb), e_rgb);
        chk(int'(cfg_err) == prev_err, "R10 width error", int'(cfg_err), prev_err);
        saw_vs = vid_vs;
        if (e_vs) begin
            if (have_len)
                chk(since_vs == exp_len, "R9 frame length after config change", since_vs, exp_len);
            have_len = 1;
            since_vs = 0;
            exp_len  = (m_hact + m_hbl) * (fl + m_vbl);
        end
        since_vs++;
        if (bh == m_hact + m_hbl - 1) begin
            bh = 0;
            if (bv == fl + m_vbl - 1) begin
                bv = 0;
                load_model();
            end else bv++;
        end else bh++;
        prev_req = int'(pix_req);
        drive_src();
    endtask

    task automatic apply_phase(int p);
        case (p)
            1: set_cfg(1, 2, 1, 1, 0, 0, 0);
            2: set_cfg(5, 3, 7, 2, 1, 1, 0);
            3: set_cfg(721, 2, 2, 1, 0, 0, 1);
            4: set_cfg(720, 2, 2, 1, 0, 1, 1);
            5: set_cfg(721, 2, 2, 1, 0, 0, 0);
            6: set_cfg(3, 2, 4, 1, 1, 0, 0);
            default: set_cfg($urandom_range(1, 24), $urandom_range(2, 6),
                             $urandom_range(2, 12), $urandom_range(1, 3),
                             $urandom_range(0, 1), $urandom_range(0, 1),
                             $urandom_range(0, 1));
        endcase
    endtask

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int phase, frames, cyc;
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        set_cfg(16, 3, 6, 2, 0, 0, 0);
        slot = 3'd0; pix = 24'd0; pskip = 1'b0;
        repeat (4) @(negedge clk);
        chk({vid_vs, vid_hs, vid_de, vid_skip, cfg_err, pix_req} == 6'd0 && vid_rgb == 24'd0,
            "R11 outputs idle in reset", int'(vid_rgb), 0);
        rst_n = 1'b1;
        drive_src();
        prev_err = 0;
        @(negedge clk);
        chk(vid_vs == 1'b0 && vid_rgb == 24'd0, "R11 quiet cycle after release", int'(vid_vs), 0);
        prev_req = int'(pix_req);
        drive_src();
        @(negedge clk);
        chk(vid_vs == 1'b1 && vid_hs == 1'b1, "R11 first frame sync", int'(vid_vs), 1);
        m_field = 0;
        load_model();
        m_field = 0;
        bh = 0; bv = 0; have_len = 0; since_vs = 0;
        phase = 0; frames = 0; cyc = 0;
        while (phase < NPH && cyc < LIMIT) begin
            step();
            if (saw_vs) begin
                frames++;
                if (frames % 2 == 0) begin
                    phase++;
                    apply_phase(phase);
                end
            end
            prev_err = (c_rot && c_hact > 12'd720) ? 1 : 0;
            cyc++;
            @(negedge clk);
        end
        if (cyc >= LIMIT) chk(0, "R1 run did not finish", cyc, LIMIT);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule